// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host read and write an external asynchronous static RAM of 1M words by 4 bits. The host raises a one-cycle request with a write flag, a 20-bit address and 4-bit write data. The block then runs a fixed sequence of clock cycles on the memory's chip-select, write-enable and output-enable lines and on a 4-bit shared data bus. It ends every access with a one-cycle completion pulse. On reads, that pulse comes together with the captured data.

Every wait length is computed at elaboration from the clock period and the memory's timing figures, given in picoseconds. The ceiling of each time divided by the clock period gives the count. The shared bus is presented as separate output data, output-enable and input data, so the pad buffer sits outside this block. Before any write, the block lets the memory's output drivers go quiet before it drives the bus itself. A parameter chooses how writes are made. With output-enable held high, the block runs an output-disable turnaround first. With output-enable held low, the block enables its drivers only once the float time after write-enable falls has passed, and it stretches the pulse to the longer minimum that this mode needs.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset, and in the first cycle after each access completes, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe and host_done are 0. Reset also clears host_rdata to 0.
- R2: host_req is acted on only when no access is in progress. A request raised during an access causes no chip-select cycle and no write.
- R3: A read holds mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 for RD = max(ceil(tAA/Tclk), ceil(tRC/Tclk)) cycles (3 at the defaults). It samples mem_dq_i at the end of the last of these cycles. host_done and host_rdata show the result RD+1 clock edges after the edge that accepted the request.
- R4: With output-enable held high during writes, a write takes three phases. First come ceil(tOHZ/Tclk) cycles with chip-select low and both strobes high and drivers off. Then write-enable is low with drivers on for max(ceil(tWP/Tclk), ceil(tDW/Tclk)) cycles. Then comes one cycle with write-enable high and drivers still on. host_done follows, 6 edges after acceptance at the defaults.
- R5: mem_dq_oe is never 1 while the memory is in read mode (cs low, we high, oe low), nor within ceil(tOHZ/Tclk) cycles after it leaves read mode.
- R6: mem_we_n is 0 only while mem_cs_n is 0.
- R7: mem_addr equals the accepted request address and does not change while mem_cs_n stays 0.
- R8: host_done is high for exactly one cycle per accepted request.
- R9: With output-enable held low during writes, mem_oe_n is 0 for every write-enable-low cycle. Drivers turn on only after ceil(tWHZ/Tclk) cycles of write-enable low. The pulse lasts at least ceil(tWP1/Tclk) cycles, and mem_oe_n rises together with mem_we_n.
- R10: Write data equals host_wdata of the accepted request. It is driven for at least ceil(tDW/Tclk) cycles before write-enable rises and is still driven in the cycle in which write-enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, sampled when idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Data from the memory |

## Verification
A wrong wait count inside the sequencer shows up in the same access. host_done arrives a cycle early or late, and a shortened read samples the bus while the bench memory is not yet driving it, which returns wrong data. A wrong state-to-pin decode shows up at once in the first affected cycle, either as drivers overlapping the memory's read window or as write-enable outside chip-select. Address-register or capture faults show up on the next read of the affected word, and the sweeps cover every data value and every address bit. A request leaking in during a busy access gives an extra chip-select fall within a cycle and a corrupted word on the following read.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    // Sequencer phases; each maps to one fixed pin pattern.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,    // oe high, we high, bus released: memory outputs floating
        ST_WFLOAT,  // we low with oe low, bus released: wait out output float
        ST_WDRIVE,  // we low, data driven
        ST_WREC     // we high again, data still held
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t CTL_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    // Whole clock cycles covering a time, never fewer than one.
    function automatic int cycles_for(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Memory-side pin pattern for a phase.
    function automatic pin_ctl_t ctl_for_state(input seq_state_e s, input logic oe_low_wr);
        pin_ctl_t c;
        c = CTL_IDLE;
        case (s)
            ST_READ:   c = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            ST_TURN:   c = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
            ST_WFLOAT: c = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b0, dq_oe: 1'b0};
            ST_WDRIVE: c = '{cs_n: 1'b0, we_n: 1'b0, oe_n: ~oe_low_wr, dq_oe: 1'b1};
            ST_WREC:   c = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            default:   c = CTL_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign last = (cnt_q == '0);

    // Wait phases shrink by exactly one per cycle, so read/write lengths hold (R3).
    assert_count_descends_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC  = 3,
    parameter int PRE_CYC = 2,
    parameter int DRV_CYC = 2,
    parameter bit OE_LOW  = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  logic     wr,
    output logic     accept,
    output logic     capture,
    output logic     done,
    output pin_ctl_t ctl
);
    localparam int MAX_CYC = max2(RD_CYC, max2(PRE_CYC, DRV_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_CYC - 1);
    localparam logic [CNT_W-1:0] DRV_LD = CNT_W'(DRV_CYC - 1);
    localparam seq_state_e WR_ENTRY = OE_LOW ? ST_WFLOAT : ST_TURN;

    seq_state_e       state_q, state_d;
    pin_ctl_t         ctl_q;
    logic             done_q, fin;
    logic             ld, last;
    logic [CNT_W-1:0] ld_val;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .last     (last)
    );

    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        accept  = 1'b0;
        capture = 1'b0;
        fin     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    ld     = 1'b1;
                    if (wr) begin
                        state_d = WR_ENTRY;
                        ld_val  = PRE_LD;
                    end else begin
                        state_d = ST_READ;
                        ld_val  = RD_LD;
                    end
                end
            end
            ST_READ: begin
                if (last) begin
                    capture = 1'b1;
                    fin     = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_TURN, ST_WFLOAT: begin
                if (last) begin
                    state_d = ST_WDRIVE;
                    ld      = 1'b1;
                    ld_val  = DRV_LD;
                end
            end
            ST_WDRIVE: begin
                if (last) begin
                    state_d = ST_WREC;
                    ld      = 1'b1;
                end
            end
            ST_WREC: begin
                fin     = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pins come straight from flops, decoded from the next phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= CTL_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_for_state(state_d, OE_LOW);
            done_q  <= fin;
        end
    end

    assign ctl  = ctl_q;
    assign done = done_q;

    assert_we_within_cs_R6: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.we_n |-> !ctl_q.cs_n);

    assert_no_drive_in_read_R5: assert property (@(posedge clk) disable iff (rst)
        ctl_q.dq_oe |-> (ctl_q.oe_n || !ctl_q.we_n));

    assert_data_held_at_we_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.we_n) |-> (ctl_q.dq_oe && ctl_q.oe_n));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (ctl_q.cs_n && ctl_q.we_n && !ctl_q.dq_oe));

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic              cs_active,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [DATA_W-1:0] rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture)
                rdata_q <= mem_dq_i;
        end
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;
    assign rdata    = rdata_q;

    assert_addr_steady_R7: assert property (@(posedge clk) disable iff (rst)
        (cs_active && $past(cs_active)) |-> $stable(addr_q));

    assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        cs_active |-> !accept);

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int DATA_W       = 4,
    parameter int CLK_PS       = 4000,
    parameter int T_AA_PS      = 10000,
    parameter int T_RC_PS      = 10000,
    parameter int T_OHZ_PS     = 5000,
    parameter int T_WHZ_PS     = 5000,
    parameter int T_WP_PS      = 7000,
    parameter int T_WP1_PS     = 10000,
    parameter int T_DW_PS      = 5000,
    parameter int T_WC_PS      = 10000,
    parameter bit WRITE_OE_LOW = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int RD_CYC   = max2(cycles_for(T_AA_PS, CLK_PS), cycles_for(T_RC_PS, CLK_PS));
    localparam int DW_CYC   = cycles_for(T_DW_PS, CLK_PS);
    localparam int WC_CYC   = cycles_for(T_WC_PS, CLK_PS);
    localparam int PRE_CYC  = WRITE_OE_LOW ? cycles_for(T_WHZ_PS, CLK_PS)
                                           : cycles_for(T_OHZ_PS, CLK_PS);
    localparam int WP_CYC   = WRITE_OE_LOW ? cycles_for(T_WP1_PS, CLK_PS)
                                           : cycles_for(T_WP_PS, CLK_PS);
    // With oe low the float wait is already part of the we-low pulse.
    localparam int DRV_BASE = WRITE_OE_LOW ? max2(DW_CYC, WP_CYC - PRE_CYC)
                                           : max2(DW_CYC, WP_CYC);
    localparam int DRV_CYC  = max2(DRV_BASE, WC_CYC - PRE_CYC - 1);

    pin_ctl_t ctl;
    logic     accept, capture;

    sram_seq_fsm #(
        .RD_CYC  (RD_CYC),
        .PRE_CYC (PRE_CYC),
        .DRV_CYC (DRV_CYC),
        .OE_LOW  (WRITE_OE_LOW)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (host_req),
        .wr      (host_wr),
        .accept  (accept),
        .capture (capture),
        .done    (host_done),
        .ctl     (ctl)
    );

    sram_data_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .cs_active (~ctl.cs_n),
        .req_addr  (host_addr),
        .req_wdata (host_wdata),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .rdata     (host_rdata)
    );

    assign mem_cs_n  = ctl.cs_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_dq_oe = ctl.dq_oe;

endmodule

// File: tb/sram_bus_model.sv
module sram_bus_model #(
    parameter bit OE_LOW    = 1'b0,
    parameter int WP_MIN    = 2,
    parameter int FLOAT_MIN = 2,
    parameter int DW_MIN    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [19:0] addr,
    input  logic [3:0]  dq_o,
    input  logic        dq_oe,
    input  logic        done,
    output logic [3:0]  dq_i,
    output int          chk,
    output int          err,
    output int          cs_falls
);
    logic [3:0]  store [64];
    logic [13:0] tag   [64];
    logic        vld   [64];

    int          since_drv, we_cnt, drv_cnt;
    logic        prev_we_n, prev_cs_n, prev_done;
    logic [19:0] prev_addr;
    logic        mem_drive;

    function automatic logic [3:0] pattern(input logic [19:0] a);
        return a[3:0] ^ a[7:4] ^ a[11:8] ^ a[15:12] ^ a[19:16] ^ 4'h5;
    endfunction

    always_comb begin
        mem_drive = !cs_n && we_n && !oe_n;
        if (!mem_drive)
            dq_i = 4'h0;
        else if (vld[addr[5:0]] && tag[addr[5:0]] == addr[19:6])
            dq_i = store[addr[5:0]];
        else
            dq_i = pattern(addr);
    end

    task automatic fail(input string tag_s, input int act, input int exp);
        err++;
        $display("FAIL %s %m: actual %0d expected %0d", tag_s, act, exp);
    endtask

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) vld[i] = 1'b0;
            since_drv = 15; we_cnt = 0; drv_cnt = 0;
            prev_we_n = 1'b1; prev_cs_n = 1'b1; prev_done = 1'b0; prev_addr = '0;
            chk = 0; err = 0; cs_falls = 0;
        end else begin
            if (mem_drive) since_drv = 0;
            else if (since_drv < 15) since_drv++;
            if (!we_n) begin
                we_cnt++;
                if (dq_oe) drv_cnt++;
            end
            // R5: no driving into the read window or its float tail
            if (dq_oe) begin
                chk++;
                if (since_drv < FLOAT_MIN) fail("R5", since_drv, FLOAT_MIN);
            end
            // R9: in oe-low mode drivers wait out the float after we falls
            if (dq_oe && !oe_n && we_cnt <= FLOAT_MIN) fail("R9", we_cnt, FLOAT_MIN + 1);
            if (!we_n) begin
                chk++;
                if (oe_n != !OE_LOW) fail(OE_LOW ? "R9" : "R4", oe_n, !OE_LOW);
                if (cs_n) fail("R6", cs_n, 0);
            end
            if (we_n && !prev_we_n) begin
                chk += 3;
                if (we_cnt < WP_MIN) fail(OE_LOW ? "R9" : "R4", we_cnt, WP_MIN);
                if (drv_cnt < DW_MIN) fail("R10", drv_cnt, DW_MIN);
                if (!dq_oe || !oe_n) fail("R10", {dq_oe, oe_n}, 3);
                store[addr[5:0]] = dq_o;
                tag[addr[5:0]]   = addr[19:6];
                vld[addr[5:0]]   = 1'b1;
                we_cnt = 0;
                drv_cnt = 0;
            end
            if (!cs_n && !prev_cs_n && addr != prev_addr) fail("R7", addr, prev_addr);
            if (cs_n && !prev_cs_n) chk++;
            if (done) begin
                chk += 2;
                if (prev_done) fail("R8", 2, 1);
                if (!(cs_n && we_n && oe_n && !dq_oe))
                    fail("R1", {cs_n, we_n, oe_n, dq_oe}, 4'b1110);
            end
            if (!cs_n && prev_cs_n) cs_falls++;
            prev_we_n = we_n;
            prev_cs_n = cs_n;
            prev_done = done;
            prev_addr = addr;
        end
    end

endmodule

// File: tb/test_async_sram_ctrl.sv
`timescale 1ns/1ps
module test_async_sram_ctrl;

    function automatic int cdiv(input int t, input int c);
        return (t + c - 1) / c;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int TCK      = 4000;
    localparam int RD_LAT   = imax(cdiv(10000, TCK), cdiv(10000, TCK)) + 1;
    localparam int WR_LAT_H = cdiv(5000, TCK) + imax(cdiv(7000, TCK), cdiv(5000, TCK)) + 2;
    localparam int WR_LAT_L = cdiv(5000, TCK)
                            + imax(cdiv(5000, TCK), cdiv(10000, TCK) - cdiv(5000, TCK)) + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [19:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;

    logic        done_a, done_b, cs_a, cs_b, we_a, we_b, oe_a, oe_b, doe_a, doe_b;
    logic [3:0]  rd_a, rd_b, dqo_a, dqo_b, dqi_a, dqi_b;
    logic [19:0] ma_a, ma_b;
    int          chk_a, err_a, csf_a, chk_b, err_b, csf_b;
    int          n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    async_sram_ctrl i_async_sram_ctrl (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_done(done_a),
        .host_rdata(rd_a), .mem_addr(ma_a), .mem_cs_n(cs_a), .mem_we_n(we_a),
        .mem_oe_n(oe_a), .mem_dq_o(dqo_a), .mem_dq_oe(doe_a), .mem_dq_i(dqi_a));

    async_sram_ctrl #(.WRITE_OE_LOW(1'b1)) i_async_sram_ctrl_oel (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_done(done_b),
        .host_rdata(rd_b), .mem_addr(ma_b), .mem_cs_n(cs_b), .mem_we_n(we_b),
        .mem_oe_n(oe_b), .mem_dq_o(dqo_b), .mem_dq_oe(doe_b), .mem_dq_i(dqi_b));

    sram_bus_model #(.OE_LOW(1'b0), .WP_MIN(cdiv(7000, TCK)), .FLOAT_MIN(cdiv(5000, TCK)),
                     .DW_MIN(cdiv(5000, TCK))) u_mem_a (
        .clk(clk), .rst(rst), .cs_n(cs_a), .we_n(we_a), .oe_n(oe_a), .addr(ma_a),
        .dq_o(dqo_a), .dq_oe(doe_a), .done(done_a), .dq_i(dqi_a),
        .chk(chk_a), .err(err_a), .cs_falls(csf_a));

    sram_bus_model #(.OE_LOW(1'b1), .WP_MIN(cdiv(10000, TCK)), .FLOAT_MIN(cdiv(5000, TCK)),
                     .DW_MIN(cdiv(5000, TCK))) u_mem_b (
        .clk(clk), .rst(rst), .cs_n(cs_b), .we_n(we_b), .oe_n(oe_b), .addr(ma_b),
        .dq_o(dqo_b), .dq_oe(doe_b), .done(done_b), .dq_i(dqi_b),
        .chk(chk_b), .err(err_b), .cs_falls(csf_b));

    function automatic logic [19:0] addr_of(input int i);
        return 20'(i * 32'h13579);
    endfunction
    function automatic logic [3:0] data_of(input int i);
        return 4'((i * 7 + 3) % 16);
    endfunction
    function automatic logic [3:0] pat(input logic [19:0] a);
        return a[3:0] ^ a[7:4] ^ a[11:8] ^ a[15:12] ^ a[19:16] ^ 4'h5;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 n_chk + chk_a + chk_b, n_err + err_a + err_b);
    endtask

    // Issue one access to both instances at a negedge and wait for both done pulses.
    task automatic do_op(input logic wr, input logic [19:0] a, input logic [3:0] d,
                         input logic [3:0] exp_rd);
        int cyc, la, lb;
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        cyc = 0; la = 0; lb = 0;
        while ((la == 0 || lb == 0) && cyc < 40) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            host_req = 1'b0;
            if (done_a && la == 0) begin
                la = cyc;
                if (!wr) check("R3 rdata oe-high", rd_a, exp_rd);
            end
            if (done_b && lb == 0) begin
                lb = cyc;
                if (!wr) check("R3 rdata oe-low", rd_b, exp_rd);
            end
        end
        if (wr) begin
            check("R4 write latency", la, WR_LAT_H);
            check("R9 write latency", lb, WR_LAT_L);
        end else begin
            check("R3 read latency oe-high", la, RD_LAT);
            check("R3 read latency oe-low", lb, RD_LAT);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R8 watchdog: no completion, actual 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        int base_a, base_b, cyc;
        logic [19:0] z;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state of both variants
        check("R1 reset pins a", {cs_a, we_a, oe_a, doe_a, done_a}, 5'b11100);
        check("R1 reset pins b", {cs_b, we_b, oe_b, doe_b, done_b}, 5'b11100);
        check("R1 reset rdata", {rd_a, rd_b}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 idle no access", csf_a + csf_b, 0);

        // Writes covering every data value and scattered addresses (R4, R9, R10)
        for (int i = 0; i < 32; i++) do_op(1'b1, addr_of(i), data_of(i), 4'h0);
        // Read back (R3, R7, R10)
        for (int i = 0; i < 32; i++) do_op(1'b0, addr_of(i), 4'h0, data_of(i));
        // Walking address bits on unwritten words (R7)
        for (int k = 0; k < 20; k++) do_op(1'b0, 20'(1 << k), 4'h0, pat(20'(1 << k)));
        do_op(1'b0, 20'hFFFFF, 4'h0, pat(20'hFFFFF));
        // Overwrite then read (R10)
        do_op(1'b1, addr_of(5), ~data_of(5), 4'h0);
        do_op(1'b0, addr_of(5), 4'h0, ~data_of(5));
        do_op(1'b0, addr_of(6), 4'h0, data_of(6));

        // R2: a write request during a read is ignored
        base_a = csf_a; base_b = csf_b;
        z = 20'h0ABCD;
        host_req = 1'b1; host_wr = 1'b0; host_addr = addr_of(3);
        @(posedge clk); @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_addr = z; host_wdata = 4'hF;
        @(posedge clk); @(negedge clk);
        host_req = 1'b0;
        cyc = 0;
        while (!done_a && cyc < 20) begin @(posedge clk); @(negedge clk); cyc++; end
        check("R2 read during ignored req", rd_a, data_of(3));
        @(negedge clk);
        check("R2 one cs cycle a", csf_a - base_a, 1);
        check("R2 one cs cycle b", csf_b - base_b, 1);
        do_op(1'b0, z, 4'h0, pat(z));
        check("R2 ignored write left word a", csf_a - base_a, 2);
        check("R2 ignored write left word b", csf_b - base_b, 2);
        check("R1 idle pins after ops", {cs_a, we_a, oe_a, doe_a, cs_b, doe_b}, 6'b111010);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule